// File: doc/BRIEF.md
# Four-Channel PWM Controller with Deferred Duty Update

The block drives a bank of pulse-width-modulated outputs, one per channel, each with its own period, duty, clock divider and output polarity. Software reaches every setting through a flat register port with an address, write data, a write strobe, a read strobe and read data. The read data is registered, so it appears one clock after the read strobe.

Each period starts with an inactive stretch set by the active duty value, and the output is active for the rest of the period. A new duty value is written to a shadow register. The channel copies that value into the active duty register only when its running period ends, so a pulse is never cut short or stretched partway through. A clear-on-read status register has one bit per channel that marks each period boundary. Software can poll this register to learn when a queued duty value has taken effect, for example before it turns a channel off.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is disabled, every output is low, and the status and enable-status registers read zero.
- R2: A write to the enable register (address 0x10) turns on each channel whose bit is 1. A write to the disable register (0x11) turns off each channel whose bit is 1. Zero bits change nothing. The enable-status register (0x13) reads back the enabled channels, with channel n at bit n.
- R3: While a channel is enabled, one period lasts P << S input clocks. P is the channel's period register (word 1) and S is the 4-bit divider field in bits 3:0 of the channel's mode register (word 0). At the clock edge where each period ends, the channel's status bit is set; it is not set before that edge.
- R4: In each period, the output is inactive for the first D prescaled ticks and active for the remaining P − D ticks, where D is the active duty value. If D ≥ P, the output stays inactive for the whole period.
- R5: Mode register bit 4 selects the polarity: 0 makes the active level high, and 1 makes it low.
- R6: While a channel is enabled, a write to its duty-update register (word 3) has no effect on the output or on the active duty readback (word 2) until the channel's next period boundary. At that boundary the active duty takes the shadow value.
- R7: While a channel is disabled, a write to its duty-update register also loads the active duty at once.
- R8: A read of the status register (0x12) returns every channel bit and clears them all. A bit set at the same edge as the read stays set.
- R9: A disabled channel drives its inactive level and holds its counters at zero. When the channel is enabled, its period starts from zero.
- R10: Channel registers sit at address {0, channel[1:0], word[1:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| we | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Read data, valid one clock after rd |
| pwm_out | output | 4 | Channel outputs |

## Verification
The bench uses the default parameters: four channels, 16-bit period and duty, and a 4-bit divider field. It keeps the random periods to 1–12 and the dividers to 1, 2 and 4 clocks. This makes every edge of a waveform, including the duty-equals-period and zero-duty cases, fall within a few dozen clocks. At that scale it is practical to check the output against a computed waveform on every single clock. Short periods also make it cheap to place a duty-update write at every phase of a period, and to line a status read up exactly with a period boundary.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NCH)+2:0]      addr,
  input  logic [CW-1:0]               wdata,
  input  logic                        we,
  input  logic                        rd,
  output logic [CW-1:0]               rdata,
  output logic [NCH-1:0]              pwm_out
);
  localparam int CHW = $clog2(NCH);
  localparam int AW  = CHW + 3;
  localparam int PCW = (1 << PW) - 1;

  logic [PW-1:0]  pre  [NCH];
  logic           pol  [NCH];
  logic [CW-1:0]  per  [NCH];
  logic [CW-1:0]  duty [NCH];
  logic [CW-1:0]  dupd [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [PCW-1:0] pcnt [NCH];
  logic [NCH-1:0] en, stat, wrap;

  wire           glb  = addr[AW-1];
  wire [1:0]     sel  = addr[1:0];
  wire [CHW-1:0] csel = addr[2 +: CHW];
  wire           wr_en  = we && glb && sel == 2'd0;
  wire           wr_dis = we && glb && sel == 2'd1;
  wire           rd_st  = rd && glb && sel == 2'd2;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire          wsel = we && !glb && csel == CHW'(i);
    wire          tick = pcnt[i] == ((PCW'(1) << pre[i]) - PCW'(1));
    wire [CW:0]   nxt  = {1'b0, cnt[i]} + 1'b1;
    wire          last = nxt >= {1'b0, per[i]};

    assign wrap[i]    = en[i] && tick && last;
    assign pwm_out[i] = pol[i] ^ (en[i] && cnt[i] >= duty[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre[i]  <= '0;
        pol[i]  <= 1'b0;
        per[i]  <= '0;
        duty[i] <= '0;
        dupd[i] <= '0;
        cnt[i]  <= '0;
        pcnt[i] <= '0;
      end else begin
        if (wsel && sel == 2'd0) {pol[i], pre[i]} <= wdata[PW:0];
        if (wsel && sel == 2'd1) per[i] <= wdata;
        if (wsel && sel == 2'd3) dupd[i] <= wdata;
        if (!en[i]) begin
          cnt[i]  <= '0;
          pcnt[i] <= '0;
          if (wsel && sel == 2'd3) duty[i] <= wdata;
        end else if (tick) begin
          pcnt[i] <= '0;
          if (last) begin
            cnt[i]  <= '0;
            duty[i] <= dupd[i];
          end else begin
            cnt[i] <= nxt[CW-1:0];
          end
        end else begin
          pcnt[i] <= pcnt[i] + 1'b1;
        end
      end
    end

    // R9: disabled channel keeps its counter at zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> cnt[i] == '0);
    // R6: active duty moves only at a boundary while enabled
    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && !wrap[i]) |=> $stable(duty[i]));
    // R3: boundary raises the status bit
    p_stat_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> stat[i]);
    // R8: read clears a bit with no concurrent boundary
    p_read_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_st && !wrap[i]) |=> !stat[i]);
    // R2: enable write with bit set turns the channel on
    p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[i] && !wr_dis) |=> en[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      stat <= '0;
    end else begin
      en   <= (en | (wr_en ? wdata[NCH-1:0] : '0)) & ~(wr_dis ? wdata[NCH-1:0] : '0);
      stat <= (rd_st ? '0 : stat) | wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (glb) begin
        case (sel)
          2'd2:    rdata <= CW'(stat);
          2'd3:    rdata <= CW'(en);
          default: rdata <= '0;
        endcase
      end else begin
        case (sel)
          2'd0: rdata <= CW'({pol[csel], pre[csel]});
          2'd1: rdata <= per[csel];
          2'd2: rdata <= duty[csel];
          2'd3: rdata <= dupd[csel];
        endcase
      end
    end
  end

  // R1: outputs low right after reset with zero polarity
  p_reset_low_r1: assert property (@(posedge clk) $rose(rst_n) |-> pwm_out == '0);
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int TCLK = 10;
  logic clk = 0, rst_n = 0, we = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0] pwm_out;
  int checks = 0, fails = 0;
  bit done = 0;

  pwm_bank u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
                  .rd(rd), .rdata(rdata), .pwm_out(pwm_out));

  always #(TCLK/2) clk = ~clk;

  function automatic logic [4:0] ca(int ch, int w);
    return {1'b0, 2'(ch), 2'(w)};
  endfunction

  function automatic int exp_out(int n, int p, int s, int pol, int d0, int d1, int wat);
    int l = p << s;
    int d = d0;
    if (wat >= 0 && n >= ((wat + 2 + l - 1) / l) * l) d = d1;
    return pol ^ ((((n >> s) % p) >= d) ? 1 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdr(logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic run(int ch, int p, int s, int pol, int d0, int d1, int wat, int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      chk("R4/R5/R6", int'(pwm_out[ch]), exp_out(n, p, s, pol, d0, d1, wat));
      if (n == wat) begin addr = ca(ch, 3); wdata = 16'(d1); we = 1; end
      @(negedge clk); we = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out", int'(pwm_out), 0);
    rdr(5'h12, v); chk("R1 status", int'(v), 0);
    rdr(5'h13, v); chk("R1 enstat", int'(v), 0);

    // R2 and R10: mask writes
    wr(5'h10, 16'h5); rdr(5'h13, v); chk("R2 enable", int'(v), 5);
    wr(5'h10, 16'h0); rdr(5'h13, v); chk("R2 zero enable", int'(v), 5);
    wr(5'h11, 16'h4); rdr(5'h13, v); chk("R2 disable", int'(v), 1);
    wr(5'h11, 16'h0); rdr(5'h13, v); chk("R2 zero disable", int'(v), 1);
    wr(5'h11, 16'hf); rdr(5'h13, v); chk("R2 all off", int'(v), 0);
    chk("R9 idle out", int'(pwm_out), 0);
    wr(ca(2, 0), 16'h13); rdr(ca(2, 0), v); chk("R10 mode readback", int'(v), 16'h13);
    wr(ca(2, 0), 16'h0);

    // R7: immediate load while disabled
    wr(ca(1, 3), 16'd9); rdr(ca(1, 2), v); chk("R7 duty", int'(v), 9);

    // R6: deferred load on a long period
    wr(ca(2, 1), 16'd200); wr(ca(2, 3), 16'd10); wr(5'h10, 16'h4);
    wr(ca(2, 3), 16'd50);
    rdr(ca(2, 2), v); chk("R6 active held", int'(v), 10);
    rdr(ca(2, 3), v); chk("R6 shadow", int'(v), 50);
    wr(5'h11, 16'h4);

    // R3 and R8: status read against a boundary, P=4 S=0
    wr(ca(3, 1), 16'd4); wr(ca(3, 3), 16'd1);
    rdr(5'h12, v);
    wr(5'h10, 16'h8);
    @(negedge clk); addr = 5'h12; rd = 1;
    @(negedge clk); rd = 0; chk("R3 early status", int'(rdata), 0);
    repeat (5) @(negedge clk);
    addr = 5'h12; rd = 1;
    @(negedge clk); rd = 0; chk("R3 first period", int'(rdata), 8);
    rdr(5'h12, v); chk("R8 concurrent kept", int'(v), 8);
    wr(5'h11, 16'h8);
    rdr(5'h12, v);
    rdr(5'h12, v); chk("R8 cleared", int'(v), 0);

    // random trials
    for (int t = 0; t < 40; t++) begin
      int ch = $urandom_range(0, 3);
      int p  = $urandom_range(1, 12);
      int s  = $urandom_range(0, 2);
      int pl = $urandom_range(0, 1);
      int d0 = $urandom_range(0, p + 1);
      int d1 = $urandom_range(0, p + 1);
      int l  = p << s;
      int wat = $urandom_range(0, l - 1);
      wr(ca(ch, 0), 16'((pl << 4) | s));
      wr(ca(ch, 1), 16'(p));
      wr(ca(ch, 3), 16'(d0));
      chk("R9 idle level", int'(pwm_out[ch]), pl);
      rdr(5'h12, v);
      wr(5'h10, 16'(1 << ch));
      run(ch, p, s, pl, d0, d1, wat, 3 * l);
      wr(5'h11, 16'(1 << ch));
      chk("R9 disabled level", int'(pwm_out[ch]), pl);
      rdr(5'h12, v); chk("R3 status bit", int'(v), 1 << ch);
      rdr(5'h12, v); chk("R8 clear on read", int'(v), 0);
      rdr(ca(ch, 2), v); chk("R6 applied duty", int'(v), d1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule